// File: doc/BRIEF.md
# Indexed Video Register Bank

This block is a slave register file for a legacy PC-style video adapter. It answers byte and word accesses on a narrow I/O port bus whose 6-bit offset counts up from the adapter's I/O base (0x3B0). Behind it sit four indexed register groups, each reached through an index port and a data port: the sequencer (5 entries), the graphics controller (9), the CRT controller (25) and the attribute controller (21). Two flat registers sit beside them: the miscellaneous output register and the palette pixel mask. Every stored byte is also presented on wide parallel outputs, so the raster, memory and palette logic downstream read their settings without using the bus.

The attribute group shares one port for index and data. A small state machine has two states, ATTR_IDX and ATTR_DATA. A write to offset 0x10 in ATTR_IDX loads the index and goes to ATTR_DATA. A write to 0x10 in ATTR_DATA stores a data byte and returns to ATTR_IDX. A read of the colour status port at offset 0x2A sends the machine to ATTR_IDX from either state. Reset enters ATTR_IDX.

Software can write an index port with a 16-bit access to set the index and the register contents in one bus cycle. Writes to the CRT controller timing registers can be locked. Reads return the current register contents combinationally in the cycle of the access. A read side effect, the status read, takes effect at the next clock edge. The bus carries at most one access per cycle.

Top module: `vidreg_bank`

## Requirements
- R1: The offset map is as follows. Sequencer index 0x14 and data 0x15. Graphics index 0x1E and data 0x1F. CRT index 0x24 and data 0x25. Attribute write 0x10 and attribute data read 0x11. Pixel mask read/write 0x16. Miscellaneous output written at 0x12 and read back at 0x1C. A read of 0x2A returns 0x00.
- R2: A byte write to an index port sets that group's index. A byte write to its data port stores the low data byte in the register selected by the current index. Reading the data port returns that register.
- R3: A word write (io_word=1) to an index port takes io_wdata[7:0] as the new index. In the same cycle it stores io_wdata[15:8] into the register at that new index. A word write to any other port uses only the low byte.
- R4: Reading an index port returns the index zero-extended. Only the implemented bits are kept: 3 bits for the sequencer, 4 for graphics and 5 for the CRT controller.
- R5: Reading an unmapped offset returns 0xFF. Reading a data port whose index points past the implemented registers also returns 0xFF. Writes to such indices change nothing.
- R6: Writes to 0x10 alternate between index phase and data phase, starting in index phase. A read of 0x2A forces index phase for the next write. In index phase, bits [4:0] become the attribute index. In data phase, the byte goes to the attribute register at that index.
- R7: Bit 5 of an attribute index-phase write drives video_en_o. Reading 0x10 returns the attribute index in bits [4:0] and the enable in bit 5.
- R8: While bit 7 of CRT register 17 (0x11) is 1, writes to CRT registers 0 to 7 are ignored. This holds for both data-port writes and word writes to the index port. All other CRT registers stay writable.
- R9: After reset, every register and index is 0x00, with one exception: graphics register 8 (bit mask) is 0xFF. Also after reset the attribute machine is in index phase and video_en_o is 0.
- R10: seq_sync_rst_o is 1 whenever bit 1 of sequencer register 0 is 0. Writing 0x01 therefore starts the synchronous reset and writing 0x03 ends it.
- R11: Graphics register 4 and graphics register 8 each hold any written value independently of each other. Bit 3 of sequencer register 4 can be toggled and reads back as written.
- R12: Register i of each group appears on its parallel output at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | Write strobe for this cycle |
| io_rd | input | 1 | Read strobe for this cycle |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_off | input | 6 | Port offset from the I/O base |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| seq_regs_o | output | 40 | Sequencer registers, flattened |
| gfx_regs_o | output | 72 | Graphics controller registers, flattened |
| crtc_regs_o | output | 200 | CRT controller registers, flattened |
| attr_regs_o | output | 168 | Attribute registers, flattened |
| misc_o | output | 8 | Miscellaneous output register |
| pel_mask_o | output | 8 | Pixel mask register |
| video_en_o | output | 1 | Video enable from attribute index bit 5 |
| seq_sync_rst_o | output | 1 | Sequencer synchronous reset active |

## Verification
The hardest case to reach from the ports is a status read that lands while the attribute machine sits in ATTR_DATA. The machine must then take the next 0x10 write as an index, and the register that was left half-addressed must stay untouched. The directed part leaves the machine in data phase on purpose, issues the status read, and then reads the stranded register back through 0x11. The random part mixes status reads, attribute writes and CRT lock toggles. This drives the flip-flop and the write lock through many interleavings, and a bench model predicts every read.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_ATR_WR = 6'h10;
    localparam logic [OFF_W-1:0] OFF_ATR_RD = 6'h11;
    localparam logic [OFF_W-1:0] OFF_MSC_WR = 6'h12;
    localparam logic [OFF_W-1:0] OFF_SEQ_A  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_SEQ_D  = 6'h15;
    localparam logic [OFF_W-1:0] OFF_PEL    = 6'h16;
    localparam logic [OFF_W-1:0] OFF_MSC_RD = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_GFX_A  = 6'h1E;
    localparam logic [OFF_W-1:0] OFF_GFX_D  = 6'h1F;
    localparam logic [OFF_W-1:0] OFF_CRT_A  = 6'h24;
    localparam logic [OFF_W-1:0] OFF_CRT_D  = 6'h25;
    localparam logic [OFF_W-1:0] OFF_STAT1  = 6'h2A;

    localparam int SEQ_NREG = 5;
    localparam int GFX_NREG = 9;
    localparam int CRT_NREG = 25;
    localparam int ATR_NREG = 21;
    localparam int SEQ_IDXW = 3;
    localparam int GFX_IDXW = 4;
    localparam int CRT_IDXW = 5;
    localparam int ATR_IDXW = 5;

    localparam int CRT_GUARD_N  = 8;
    localparam int CRT_LOCK_REG = 17;
    localparam int GFX_MASK_REG = 8;
    localparam int ATR_VEN_BIT  = 5;

    typedef enum logic {
        ATTR_IDX  = 1'b0,
        ATTR_DATA = 1'b1
    } attr_phase_t;
endpackage

// File: rtl/vidreg_idx_bank.sv
module vidreg_idx_bank #(
    parameter int         NREGS   = 5,
    parameter int         IDX_W   = 3,
    parameter int         GUARD_N = 0,
    parameter int         SPECIAL = 0,
    parameter logic [7:0] SPECIAL_RST = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic [7:0]         idx_in,
    input  logic               data_we,
    input  logic [7:0]         data_in,
    input  logic               lock,
    output logic [IDX_W-1:0]   idx_q,
    output logic [NREGS*8-1:0] regs_flat,
    output logic [7:0]         rd_data
);
    logic [IDX_W-1:0] wr_idx;
    logic             blocked;

    assign wr_idx = idx_we ? idx_in[IDX_W-1:0] : idx_q;

    generate
        if (GUARD_N > 0) begin : g_guard
            localparam logic [IDX_W-1:0] GUARD_LIM = IDX_W'(GUARD_N);
            assign blocked = lock && (wr_idx < GUARD_LIM);
        end else begin : g_noguard
            assign blocked = lock & 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= idx_in[IDX_W-1:0];
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [7:0] RV = (i == SPECIAL) ? SPECIAL_RST : 8'h00;
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RV;
            else if (data_we && !blocked && (wr_idx == IDX_W'(i)))
                q <= data_in;
        end
        assign regs_flat[i*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NREGS; k++) begin
            if (idx_q == IDX_W'(k)) rd_data = regs_flat[k*8 +: 8];
        end
    end
endmodule

// File: rtl/vidreg_attr_fsm.sv
module vidreg_attr_fsm
    import vidreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_wr,
    input  logic stat_rd,
    input  logic en_bit,
    output logic idx_we,
    output logic data_we,
    output logic video_en,
    output logic in_data
);
    attr_phase_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ATTR_IDX:  if (stat_rd) nxt = ATTR_IDX;  else if (port_wr) nxt = ATTR_DATA;
            ATTR_DATA: if (stat_rd) nxt = ATTR_IDX;  else if (port_wr) nxt = ATTR_IDX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ATTR_IDX;
        else        state <= nxt;
    end

    always_comb begin
        idx_we  = 1'b0;
        data_we = 1'b0;
        unique case (state)
            ATTR_IDX:  idx_we  = port_wr;
            ATTR_DATA: data_we = port_wr;
        endcase
        in_data = (state == ATTR_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      video_en <= 1'b0;
        else if (idx_we) video_en <= en_bit;
    end
endmodule

// File: rtl/vidreg_bank.sv
module vidreg_bank
    import vidreg_pkg::*;
#(
    parameter int SEQ_N = SEQ_NREG,
    parameter int GFX_N = GFX_NREG,
    parameter int CRT_N = CRT_NREG,
    parameter int ATR_N = ATR_NREG,
    parameter int SEQ_IW = SEQ_IDXW,
    parameter int GFX_IW = GFX_IDXW,
    parameter int CRT_IW = CRT_IDXW,
    parameter int ATR_IW = ATR_IDXW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic               io_word,
    input  logic [OFF_W-1:0]   io_off,
    input  logic [15:0]        io_wdata,
    output logic [7:0]         io_rdata,
    output logic [SEQ_N*8-1:0] seq_regs_o,
    output logic [GFX_N*8-1:0] gfx_regs_o,
    output logic [CRT_N*8-1:0] crtc_regs_o,
    output logic [ATR_N*8-1:0] attr_regs_o,
    output logic [7:0]         misc_o,
    output logic [7:0]         pel_mask_o,
    output logic               video_en_o,
    output logic               seq_sync_rst_o
);
    logic [SEQ_IW-1:0] seq_idx;
    logic [GFX_IW-1:0] gfx_idx;
    logic [CRT_IW-1:0] crtc_idx;
    logic [ATR_IW-1:0] attr_idx;
    logic [7:0] seq_rd, gfx_rd, crt_rd, atr_rd;
    logic       attr_ph, atr_idx_we, atr_data_we;

    logic wr_seq_a, wr_gfx_a, wr_crt_a;
    assign wr_seq_a = io_wr && (io_off == OFF_SEQ_A);
    assign wr_gfx_a = io_wr && (io_off == OFF_GFX_A);
    assign wr_crt_a = io_wr && (io_off == OFF_CRT_A);

    logic [7:0] hi_lo;
    assign hi_lo = io_wdata[7:0];

    vidreg_idx_bank #(.NREGS(SEQ_N), .IDX_W(SEQ_IW), .GUARD_N(0), .SPECIAL(0), .SPECIAL_RST(8'h00)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_we(wr_seq_a), .idx_in(hi_lo),
        .data_we((wr_seq_a && io_word) || (io_wr && io_off == OFF_SEQ_D)),
        .data_in(wr_seq_a ? io_wdata[15:8] : io_wdata[7:0]),
        .lock(1'b0),
        .idx_q(seq_idx), .regs_flat(seq_regs_o), .rd_data(seq_rd)
    );

    vidreg_idx_bank #(.NREGS(GFX_N), .IDX_W(GFX_IW), .GUARD_N(0), .SPECIAL(GFX_MASK_REG), .SPECIAL_RST(8'hFF)) u_gfx (
        .clk(clk), .rst_n(rst_n),
        .idx_we(wr_gfx_a), .idx_in(hi_lo),
        .data_we((wr_gfx_a && io_word) || (io_wr && io_off == OFF_GFX_D)),
        .data_in(wr_gfx_a ? io_wdata[15:8] : io_wdata[7:0]),
        .lock(1'b0),
        .idx_q(gfx_idx), .regs_flat(gfx_regs_o), .rd_data(gfx_rd)
    );

    logic crt_lock;
    assign crt_lock = crtc_regs_o[CRT_LOCK_REG*8 + 7];

    vidreg_idx_bank #(.NREGS(CRT_N), .IDX_W(CRT_IW), .GUARD_N(CRT_GUARD_N), .SPECIAL(0), .SPECIAL_RST(8'h00)) u_crt (
        .clk(clk), .rst_n(rst_n),
        .idx_we(wr_crt_a), .idx_in(hi_lo),
        .data_we((wr_crt_a && io_word) || (io_wr && io_off == OFF_CRT_D)),
        .data_in(wr_crt_a ? io_wdata[15:8] : io_wdata[7:0]),
        .lock(crt_lock),
        .idx_q(crtc_idx), .regs_flat(crtc_regs_o), .rd_data(crt_rd)
    );

    vidreg_attr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .port_wr(io_wr && io_off == OFF_ATR_WR),
        .stat_rd(io_rd && io_off == OFF_STAT1),
        .en_bit(io_wdata[ATR_VEN_BIT]),
        .idx_we(atr_idx_we), .data_we(atr_data_we),
        .video_en(video_en_o), .in_data(attr_ph)
    );

    vidreg_idx_bank #(.NREGS(ATR_N), .IDX_W(ATR_IW), .GUARD_N(0), .SPECIAL(0), .SPECIAL_RST(8'h00)) u_atr (
        .clk(clk), .rst_n(rst_n),
        .idx_we(atr_idx_we), .idx_in(hi_lo),
        .data_we(atr_data_we), .data_in(io_wdata[7:0]),
        .lock(1'b0),
        .idx_q(attr_idx), .regs_flat(attr_regs_o), .rd_data(atr_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misc_o     <= 8'h00;
            pel_mask_o <= 8'h00;
        end else if (io_wr) begin
            if (io_off == OFF_MSC_WR) misc_o     <= io_wdata[7:0];
            if (io_off == OFF_PEL)    pel_mask_o <= io_wdata[7:0];
        end
    end

    assign seq_sync_rst_o = ~seq_regs_o[1];

    always_comb begin
        io_rdata = 8'hFF;
        unique case (io_off)
            OFF_ATR_WR: begin
                io_rdata = 8'h00;
                io_rdata[ATR_IW-1:0] = attr_idx;
                io_rdata[ATR_VEN_BIT] = video_en_o;
            end
            OFF_ATR_RD: io_rdata = atr_rd;
            OFF_SEQ_A:  io_rdata = {{(8-SEQ_IW){1'b0}}, seq_idx};
            OFF_SEQ_D:  io_rdata = seq_rd;
            OFF_PEL:    io_rdata = pel_mask_o;
            OFF_MSC_RD: io_rdata = misc_o;
            OFF_GFX_A:  io_rdata = {{(8-GFX_IW){1'b0}}, gfx_idx};
            OFF_GFX_D:  io_rdata = gfx_rd;
            OFF_CRT_A:  io_rdata = {{(8-CRT_IW){1'b0}}, crtc_idx};
            OFF_CRT_D:  io_rdata = crt_rd;
            OFF_STAT1:  io_rdata = 8'h00;
            default:    io_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/vidreg_bank_chk.sv
module vidreg_bank_chk
    import vidreg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic                  io_word,
    input logic [OFF_W-1:0]      io_off,
    input logic [15:0]           io_wdata,
    input logic [7:0]            io_rdata,
    input logic [GFX_NREG*8-1:0] gfx_regs_o,
    input logic [CRT_NREG*8-1:0] crtc_regs_o,
    input logic                  video_en_o,
    input logic                  seq_sync_rst_o,
    input logic                  attr_ph,
    input logic [CRT_IDXW-1:0]   crtc_idx,
    input logic [GFX_IDXW-1:0]   gfx_idx
);
    logic mapped;
    assign mapped = (io_off == OFF_ATR_WR) || (io_off == OFF_ATR_RD) || (io_off == OFF_SEQ_A) ||
                    (io_off == OFF_SEQ_D) || (io_off == OFF_PEL) || (io_off == OFF_MSC_RD) ||
                    (io_off == OFF_GFX_A) || (io_off == OFF_GFX_D) || (io_off == OFF_CRT_A) ||
                    (io_off == OFF_CRT_D) || (io_off == OFF_STAT1);

    p_seq_idx_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_off == OFF_SEQ_A) |-> (io_rdata[7:3] == 5'd0));

    p_gfx_idx_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_off == OFF_GFX_A) |-> (io_rdata[7:4] == 4'd0));

    p_unmapped_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !mapped) |-> (io_rdata == 8'hFF));

    p_stat_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_off == OFF_STAT1) |=> !attr_ph);

    p_attr_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && io_off == OFF_ATR_WR) |=> (attr_ph != $past(attr_ph)));

    p_video_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && io_off == OFF_ATR_WR && !attr_ph) |=> (video_en_o == $past(io_wdata[ATR_VEN_BIT])));

    p_crt_lock_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == OFF_CRT_D && crtc_idx < 5'd8 && crtc_regs_o[CRT_LOCK_REG*8+7])
        |=> $stable(crtc_regs_o[CRT_GUARD_N*8-1:0]));

    p_crt_lock_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_word && io_off == OFF_CRT_A && io_wdata[7:0] < 8'd8 && crtc_regs_o[CRT_LOCK_REG*8+7])
        |=> $stable(crtc_regs_o[CRT_GUARD_N*8-1:0]));

    p_gfx_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == OFF_GFX_D && gfx_idx == 4'd4)
        |=> $stable(gfx_regs_o[GFX_MASK_REG*8 +: 8]));

    p_sync_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_word && io_off == OFF_SEQ_A && io_wdata[7:0] == 8'h00)
        |=> (seq_sync_rst_o == !$past(io_wdata[9])));
endmodule

bind vidreg_bank vidreg_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_word(io_word),
    .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .gfx_regs_o(gfx_regs_o), .crtc_regs_o(crtc_regs_o),
    .video_en_o(video_en_o), .seq_sync_rst_o(seq_sync_rst_o),
    .attr_ph(attr_ph), .crtc_idx(crtc_idx), .gfx_idx(gfx_idx)
);

// File: tb/vidreg_bank_test.sv
`timescale 1ns/1ps
module vidreg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_word = 1'b0;
    logic [5:0]  io_off = 6'h00;
    logic [15:0] io_wdata = 16'h0000;
    logic [7:0]  io_rdata;
    logic [39:0]  seq_regs_o;
    logic [71:0]  gfx_regs_o;
    logic [199:0] crtc_regs_o;
    logic [167:0] attr_regs_o;
    logic [7:0]  misc_o, pel_mask_o;
    logic        video_en_o, seq_sync_rst_o;

    always #4 clk = ~clk;

    vidreg_bank uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_word(io_word),
        .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .seq_regs_o(seq_regs_o), .gfx_regs_o(gfx_regs_o), .crtc_regs_o(crtc_regs_o),
        .attr_regs_o(attr_regs_o), .misc_o(misc_o), .pel_mask_o(pel_mask_o),
        .video_en_o(video_en_o), .seq_sync_rst_o(seq_sync_rst_o)
    );

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] m_seq [5];
    logic [7:0] m_gfx [9];
    logic [7:0] m_crt [25];
    logic [7:0] m_atr [21];
    logic [7:0] m_misc, m_pel;
    logic [2:0] m_sidx;
    logic [3:0] m_gidx;
    logic [4:0] m_cidx, m_aidx;
    logic       m_ven, m_ph;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_seq[i]) m_seq[i] = 8'h00;
        foreach (m_gfx[i]) m_gfx[i] = 8'h00;
        foreach (m_crt[i]) m_crt[i] = 8'h00;
        foreach (m_atr[i]) m_atr[i] = 8'h00;
        m_gfx[8] = 8'hFF;
        m_misc = 0; m_pel = 0; m_sidx = 0; m_gidx = 0; m_cidx = 0; m_aidx = 0;
        m_ven = 0; m_ph = 0;
    endtask

    task automatic crt_put(input logic [7:0] v);
        if (m_cidx < 25 && !(m_crt[17][7] && m_cidx < 8)) m_crt[m_cidx] = v;
    endtask

    task automatic model_wr(input logic [5:0] off, input logic [15:0] d, input bit word);
        case (off)
            6'h10: begin
                if (!m_ph) begin m_aidx = d[4:0]; m_ven = d[5]; m_ph = 1; end
                else begin if (m_aidx < 21) m_atr[m_aidx] = d[7:0]; m_ph = 0; end
            end
            6'h12: m_misc = d[7:0];
            6'h16: m_pel = d[7:0];
            6'h14: begin m_sidx = d[2:0]; if (word && m_sidx < 5) m_seq[m_sidx] = d[15:8]; end
            6'h15: if (m_sidx < 5) m_seq[m_sidx] = d[7:0];
            6'h1E: begin m_gidx = d[3:0]; if (word && m_gidx < 9) m_gfx[m_gidx] = d[15:8]; end
            6'h1F: if (m_gidx < 9) m_gfx[m_gidx] = d[7:0];
            6'h24: begin m_cidx = d[4:0]; if (word) crt_put(d[15:8]); end
            6'h25: crt_put(d[7:0]);
            default: ;
        endcase
    endtask

    function automatic logic [7:0] exp_rd(input logic [5:0] off);
        case (off)
            6'h10: return {2'b00, m_ven, m_aidx};
            6'h11: return (m_aidx < 21) ? m_atr[m_aidx] : 8'hFF;
            6'h14: return {5'd0, m_sidx};
            6'h15: return (m_sidx < 5) ? m_seq[m_sidx] : 8'hFF;
            6'h16: return m_pel;
            6'h1C: return m_misc;
            6'h1E: return {4'd0, m_gidx};
            6'h1F: return (m_gidx < 9) ? m_gfx[m_gidx] : 8'hFF;
            6'h24: return {3'd0, m_cidx};
            6'h25: return (m_cidx < 25) ? m_crt[m_cidx] : 8'hFF;
            6'h2A: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic wr(input logic [5:0] off, input logic [15:0] d, input bit word);
        @(negedge clk);
        io_wr = 1; io_rd = 0; io_word = word; io_off = off; io_wdata = d;
        model_wr(off, d, word);
        @(posedge clk); #1;
        io_wr = 0; io_word = 0;
    endtask

    task automatic rd(input logic [5:0] off, input string req);
        @(negedge clk);
        io_wr = 0; io_rd = 1; io_word = 0; io_off = off;
        #1;
        chk(req, io_rdata, exp_rd(off));
        if (off == 6'h2A) m_ph = 0;
        @(posedge clk); #1;
        io_rd = 0;
    endtask

    task automatic chk_par(input string req);
        for (int i = 0; i < 5; i++)  chk(req, seq_regs_o[i*8 +: 8], m_seq[i]);
        for (int i = 0; i < 9; i++)  chk(req, gfx_regs_o[i*8 +: 8], m_gfx[i]);
        for (int i = 0; i < 25; i++) chk(req, crtc_regs_o[i*8 +: 8], m_crt[i]);
        for (int i = 0; i < 21; i++) chk(req, attr_regs_o[i*8 +: 8], m_atr[i]);
        chk(req, misc_o, m_misc);
        chk(req, pel_mask_o, m_pel);
        chk(req, {7'd0, video_en_o}, {7'd0, m_ven});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] offs [12];
        logic [15:0] d;
        logic [5:0] o;
        offs = '{6'h10, 6'h11, 6'h12, 6'h14, 6'h15, 6'h16, 6'h1C, 6'h1E, 6'h1F, 6'h24, 6'h25, 6'h2A};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R9: reset state
        chk_par("R9");
        chk("R9 sync", {7'd0, seq_sync_rst_o}, 8'd1);
        rd(6'h1E, "R9"); rd(6'h10, "R9");

        // R1: miscellaneous and pixel mask
        wr(6'h12, 16'h00E3, 0); rd(6'h1C, "R1"); rd(6'h12, "R5");
        wr(6'h16, 16'h005A, 0); rd(6'h16, "R1"); rd(6'h2A, "R1");

        // R2: byte index then data
        wr(6'h14, 16'h0002, 0); wr(6'h15, 16'h000F, 0);
        rd(6'h15, "R2"); rd(6'h14, "R2");

        // R3, R10: word writes
        wr(6'h14, 16'h0300, 1); rd(6'h15, "R3");
        chk("R10 end", {7'd0, seq_sync_rst_o}, 8'd0);
        wr(6'h14, 16'h0100, 1);
        chk("R10 start", {7'd0, seq_sync_rst_o}, 8'd1);
        wr(6'h1E, 16'h7705, 1); rd(6'h1F, "R3");
        wr(6'h16, 16'hAB11, 1); rd(6'h16, "R3");

        // R4: index masking
        wr(6'h1E, 16'h00F8, 0); rd(6'h1E, "R4");
        wr(6'h14, 16'h00FC, 0); rd(6'h14, "R4");
        wr(6'h24, 16'h00F3, 0); rd(6'h24, "R4");

        // R5: unimplemented index
        wr(6'h14, 16'h0007, 0); wr(6'h15, 16'h0055, 0); rd(6'h15, "R5");
        wr(6'h24, 16'h001D, 0); wr(6'h25, 16'h0066, 0); rd(6'h25, "R5");
        chk_par("R5"); rd(6'h3F, "R5"); rd(6'h00, "R5");

        // R11: read map / bit mask independence, chain4 toggle
        wr(6'h1E, 16'h0004, 0); wr(6'h1F, 16'h0003, 0);
        wr(6'h1E, 16'h0008, 0);
        for (int v = 8'hBB; v != 0; v = v >> 1) begin
            wr(6'h1F, 16'(v), 0); rd(6'h1F, "R11");
        end
        wr(6'h1E, 16'h0004, 0); rd(6'h1F, "R11");
        wr(6'h14, 16'h0604, 1); wr(6'h15, 16'h000E, 0); rd(6'h15, "R11");
        wr(6'h15, 16'h0006, 0); rd(6'h15, "R11");

        // R6, R7: attribute flip-flop
        rd(6'h2A, "R6");
        wr(6'h10, 16'h0020, 0);
        chk("R7 ven", {7'd0, video_en_o}, 8'd1);
        rd(6'h10, "R7");
        wr(6'h10, 16'h003C, 0); rd(6'h11, "R6");
        wr(6'h10, 16'h0005, 0);
        chk("R7 ven off", {7'd0, video_en_o}, 8'd0);
        rd(6'h2A, "R6");
        wr(6'h10, 16'h0007, 0); rd(6'h10, "R6");
        wr(6'h10, 16'h0025, 0);
        rd(6'h2A, "R6"); wr(6'h10, 16'h0005, 0); rd(6'h11, "R6");
        rd(6'h2A, "R6"); wr(6'h10, 16'h0007, 0); rd(6'h11, "R6");

        // R8: CRT write lock
        wr(6'h24, 16'h8011, 1);
        wr(6'h24, 16'h3302, 1); rd(6'h25, "R8");
        wr(6'h25, 16'h0044, 0); rd(6'h25, "R8");
        wr(6'h24, 16'h4409, 1); rd(6'h25, "R8");
        wr(6'h24, 16'h0011, 1);
        wr(6'h24, 16'h3302, 1); rd(6'h25, "R8");
        chk_par("R8");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int k;
            k = int'($urandom % 13);
            o = (k == 12) ? 6'($urandom) : offs[k];
            d = 16'($urandom);
            if (o == 6'h14 || o == 6'h1E || o == 6'h24) d[7:5] = 3'b000;
            if ($urandom % 2) wr(o, d, 1'($urandom)); else rd(o, "R2 random");
        end
        chk_par("R12");

        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule